// File: doc/BRIEF.md
# Request/Acknowledge Word Bridge Between Clock Domains

This block moves single data words from a sending clock domain into a receiving clock domain whose clock has no fixed relation to the sender's. The sender offers a word with a valid/ready pair. Once the word is taken, the sending side keeps it in a holding register that drives a bus to the far side, and it raises a request line. Only the request line and the returning acknowledge line cross the boundary. Each passes through a chain of flip-flops clocked in the domain that reads it. The data bus is never resynchronized. It is simply held still until the handshake proves that the far side has already latched it.

The receiving side latches the bus once its synchronized copy of the request goes high. It raises an acknowledge and pulses a one-cycle valid strobe together with the captured word. Both lines return to low in a four-phase sequence. The request falls once the synchronized acknowledge is seen, and the acknowledge falls once the synchronized request is seen low. The sender becomes ready again only after it sees the acknowledge low. Each domain has its own active-low asynchronous reset. This block is meant for occasional transfers of configuration or status words, not for streaming data.

Top module: `xdom_word_bridge`

## Requirements
- R1: After both resets are released, and before any word is offered, `snd_ready` is 1 and `rcv_valid` is 0.
- R2: A word is accepted on a rising `snd_clk` edge where `snd_valid` and `snd_ready` are both 1. `snd_ready` is 0 from the next cycle until that word's handshake has completed.
- R3: Every accepted word appears on `rcv_data`, unchanged and in the order it was accepted.
- R4: Values on `snd_valid` and `snd_data` while `snd_ready` is 0 have no effect. No extra word is delivered and no delivered word is altered.
- R5: `rcv_valid` is high for exactly one `rcv_clk` cycle per accepted word and is never high in two consecutive cycles.
- R6: With `SYNC_STAGES` synchronizer flops, `rcv_valid` rises on the (`SYNC_STAGES`+1)-th rising `rcv_clk` edge after the accepting `snd_clk` edge. The acknowledge rises only on a cycle in which the synchronized request is high.
- R7: The request falls only after the synchronized acknowledge has been seen high. The acknowledge falls only after the synchronized request has been seen low. A new request rises only while the synchronized acknowledge is low. `snd_ready` therefore returns only after the word has been delivered, and no sooner than 2*(`SYNC_STAGES`+1) `snd_clk` cycles after acceptance.
- R8: The bus carried to the receiving domain does not change while a request is outstanding, that is, in any cycle in which the sender is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending-domain clock |
| snd_rst_n | input | 1 | Sending-domain asynchronous reset, active low |
| snd_valid | input | 1 | A word is offered on snd_data |
| snd_data | input | DATA_W | Offered word |
| snd_ready | output | 1 | Sender is idle and takes a word this cycle |
| rcv_clk | input | 1 | Receiving-domain clock |
| rcv_rst_n | input | 1 | Receiving-domain asynchronous reset, active low |
| rcv_valid | output | 1 | One-cycle strobe: rcv_data holds a new word |
| rcv_data | output | DATA_W | Last captured word |

## Verification
The properties assume that the two domains leave reset together and that neither reset is applied alone in the middle of a transfer. If one domain is reset alone, the request or acknowledge may be left high on the other side. The stimulus releases both resets once and never again. It holds `snd_valid` high with unrelated data while the bridge is busy, but drops it in the same cycle that `snd_ready` returns, so that no word is taken that the bench did not intend to send. Every word value is swept under a slower and a faster receive clock. The receive edges are placed so that they never coincide with sending edges, which makes the latency in edges exact.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

    typedef enum logic [1:0] {
        SND_IDLE  = 2'd0,
        SND_REQ   = 2'd1,
        SND_DRAIN = 2'd2
    } snd_state_e;

endpackage

// File: rtl/xdb_bit_sync.sv
module xdb_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    localparam int CHAIN_W = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN_W-1:0] chain_d;
    logic [CHAIN_W-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[CHAIN_W-1];

endmodule

// File: rtl/xdb_sender.sv
module xdb_sender
    import xdb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offer_valid,
    input  logic [DATA_W-1:0] offer_data,
    output logic              offer_ready,
    output logic              req_out,
    output logic [DATA_W-1:0] bus_out,
    input  logic              ack_async
);

    typedef struct packed {
        snd_state_e        state;
        logic              req;
        logic [DATA_W-1:0] bus;
    } snd_regs_t;

    snd_regs_t cur_q;
    snd_regs_t nxt_d;
    logic      ack_s;

    xdb_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_async),
        .sync_out (ack_s)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            SND_IDLE: begin
                if (offer_valid) begin
                    nxt_d.state = SND_REQ;
                    nxt_d.req   = 1'b1;
                    nxt_d.bus   = offer_data;
                end
            end
            SND_REQ: begin
                if (ack_s) begin
                    nxt_d.state = SND_DRAIN;
                    nxt_d.req   = 1'b0;
                end
            end
            SND_DRAIN: begin
                if (!ack_s) begin
                    nxt_d.state = SND_IDLE;
                end
            end
            default: begin
                nxt_d.state = SND_IDLE;
                nxt_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: SND_IDLE, req: 1'b0, bus: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign offer_ready = (cur_q.state == SND_IDLE);
    assign req_out     = cur_q.req;
    assign bus_out     = cur_q.bus;

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state != SND_IDLE) |=> $stable(cur_q.bus)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.req |-> !offer_ready); // R2
    AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.req) |-> !$past(ack_s)); // R7
    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.req) |-> $past(ack_s)); // R7

endmodule

// File: rtl/xdb_receiver.sv
module xdb_receiver #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] bus_in,
    output logic              ack_out,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data
);

    typedef struct packed {
        logic              ack;
        logic              strobe;
        logic [DATA_W-1:0] data;
    } rcv_regs_t;

    rcv_regs_t cur_q;
    rcv_regs_t nxt_d;
    logic      req_s;

    xdb_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_async),
        .sync_out (req_s)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.strobe = 1'b0;
        if (req_s && !cur_q.ack) begin
            nxt_d.ack    = 1'b1;
            nxt_d.strobe = 1'b1;
            nxt_d.data   = bus_in;
        end else if (!req_s && cur_q.ack) begin
            nxt_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ack: 1'b0, strobe: 1'b0, data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_out    = cur_q.ack;
    assign word_valid = cur_q.strobe;
    assign word_data  = cur_q.data;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.strobe |=> !cur_q.strobe); // R5
    AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ack) |-> $past(req_s)); // R6
    AST_ACK_DROP_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.ack) |-> !$past(req_s)); // R7

endmodule

// File: rtl/xdom_word_bridge.sv
module xdom_word_bridge #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              snd_clk,
    input  logic              snd_rst_n,
    input  logic              snd_valid,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_ready,
    input  logic              rcv_clk,
    input  logic              rcv_rst_n,
    output logic              rcv_valid,
    output logic [DATA_W-1:0] rcv_data
);

    logic              req_line;
    logic              ack_line;
    logic [DATA_W-1:0] held_bus;

    xdb_sender #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sender (
        .clk         (snd_clk),
        .rst_n       (snd_rst_n),
        .offer_valid (snd_valid),
        .offer_data  (snd_data),
        .offer_ready (snd_ready),
        .req_out     (req_line),
        .bus_out     (held_bus),
        .ack_async   (ack_line)
    );

    xdb_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_receiver (
        .clk        (rcv_clk),
        .rst_n      (rcv_rst_n),
        .req_async  (req_line),
        .bus_in     (held_bus),
        .ack_out    (ack_line),
        .word_valid (rcv_valid),
        .word_data  (rcv_data)
    );

endmodule

// File: tb/tb_xdom_word_bridge.sv
module tb_xdom_word_bridge;

    localparam int SND_PERIOD  = 10;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int NWORDS      = 1 << DATA_W;
    localparam int MAXW        = 2 * NWORDS;
    localparam int WATCHDOG    = 150000;

    logic              snd_clk = 1'b0;
    logic              rcv_clk = 1'b0;
    logic              snd_rst_n = 1'b0;
    logic              rcv_rst_n = 1'b0;
    logic              snd_valid = 1'b0;
    logic [DATA_W-1:0] snd_data  = '0;
    logic              snd_ready;
    logic              rcv_valid;
    logic [DATA_W-1:0] rcv_data;

    int checks = 0;
    int failures = 0;
    int sent = 0;
    int rcvd = 0;
    int rcv_edges = 0;
    int snd_cycles = 0;
    int rcv_half = 7;
    bit prev_valid = 1'b0;
    bit done = 1'b0;
    logic [DATA_W-1:0] want_data [MAXW];
    int                snap_edge [MAXW];

    xdom_word_bridge #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dut (
        .snd_clk   (snd_clk),
        .snd_rst_n (snd_rst_n),
        .snd_valid (snd_valid),
        .snd_data  (snd_data),
        .snd_ready (snd_ready),
        .rcv_clk   (rcv_clk),
        .rcv_rst_n (rcv_rst_n),
        .rcv_valid (rcv_valid),
        .rcv_data  (rcv_data)
    );

    // sending clock: rising edges at odd times (5, 15, ...)
    always #(SND_PERIOD / 2) snd_clk = ~snd_clk;

    // receiving clock: even period, rising edges at even times only
    initial begin
        #2;
        forever begin
            rcv_clk = 1'b1;
            #(rcv_half);
            rcv_clk = 1'b0;
            #(rcv_half);
        end
    end

    always @(posedge rcv_clk) rcv_edges <= rcv_edges + 1;
    always @(posedge snd_clk) snd_cycles <= snd_cycles + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // receive-side monitor
    always @(negedge rcv_clk) begin
        if (rcv_rst_n && snd_rst_n) begin
            check(!(prev_valid && rcv_valid), "R5 strobe longer than one cycle", int'(rcv_valid), 0);
            if (rcv_valid) begin
                check(rcvd < sent, "R4 R5 word delivered without acceptance", rcvd, sent);
                if (rcvd < sent) begin
                    check(rcv_data == want_data[rcvd], "R3 R8 delivered word", int'(rcv_data), int'(want_data[rcvd]));
                    check(rcv_edges - snap_edge[rcvd] == SYNC_STAGES + 1, "R6 latency in receive edges",
                          rcv_edges - snap_edge[rcvd], SYNC_STAGES + 1);
                end
                rcvd++;
            end
            prev_valid = rcv_valid;
        end
    end

    task automatic send_word(input logic [DATA_W-1:0] v, input int gap);
        int waited;
        @(negedge snd_clk);
        snd_valid = 1'b1;
        snd_data  = v;
        while (!snd_ready) @(negedge snd_clk);
        @(posedge snd_clk);
        want_data[sent] = v;
        snap_edge[sent] = rcv_edges;
        sent++;
        @(negedge snd_clk);
        check(snd_ready == 1'b0, "R2 ready after accept", int'(snd_ready), 0);
        // busy: offer unrelated data, which must be ignored
        snd_valid = (gap != 1);
        snd_data  = ~v;
        waited = 0;
        while (!snd_ready) begin
            @(negedge snd_clk);
            waited++;
        end
        snd_valid = 1'b0;
        check(rcvd == sent, "R7 ready before delivery", rcvd, sent);
        check(waited >= 2 * (SYNC_STAGES + 1), "R7 handshake cycles", waited, 2 * (SYNC_STAGES + 1));
        for (int i = 0; i < gap; i++) @(negedge snd_clk);
    endtask

    initial begin
        repeat (4) @(negedge snd_clk);
        snd_rst_n = 1'b1;
        rcv_rst_n = 1'b1;
        repeat (3) @(negedge snd_clk);
        check(snd_ready == 1'b1, "R1 ready after reset", int'(snd_ready), 1);
        check(rcv_valid == 1'b0, "R1 valid after reset", int'(rcv_valid), 0);

        // phase 1: receiving clock slower than sending clock
        for (int v = 0; v < NWORDS; v++) send_word(DATA_W'(v), v % 3);
        repeat (40) @(negedge snd_clk);
        check(rcvd == sent, "R5 one strobe per word, slow receiver", rcvd, sent);

        // phase 2: receiving clock faster than sending clock
        rcv_half = 3;
        for (int v = 0; v < NWORDS; v++) send_word(DATA_W'((NWORDS - 1 - v) ^ 8'h5A), (v + 1) % 3);
        repeat (40) @(negedge snd_clk);
        check(rcvd == sent, "R5 one strobe per word, fast receiver", rcvd, sent);
        check(rcvd == MAXW, "R3 total words", rcvd, MAXW);
        done = 1'b1;
    end

    initial begin
        wait (done || snd_cycles >= WATCHDOG);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", snd_cycles, WATCHDOG);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule